// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Array

This block holds a two-bit state for each of `NUM_SRC` edge-triggered interrupt sources. One bit marks an event that has been sent downstream and not yet completed (pending), the other marks that a further event arrived while the first was still in flight (queued). A hardware trigger pulse on a source sends a notification carrying that source's number to a downstream router only when the source's state allows it. Repeated triggers are folded into the queued bit, and they are replayed as one fresh notification when software completes the interrupt.

Software reaches every source through a small memory-mapped port. The address holds the source number above a three-bit operation offset. The operation can complete an interrupt (end-of-interrupt), read the state with no side effect, or force the state to any of its four values. Every operation returns the state as it was before the access. Several sources may trigger in the same cycle. Their notifications wait in per-source forward flags and leave through a single valid/ready output, one per cycle, in round-robin order.

Top module: `pq_src_array`

## Requirements
- R1: After reset every source state reads as PQ=01 (off) and `notif_valid_o` is low.
- R2: A trigger on a source in state PQ=00 moves it to PQ=10 and produces exactly one notification whose `notif_src_o` is that source's number.
- R3: A trigger on a source in state PQ=10 or PQ=11 moves it to PQ=11 and produces no notification.
- R4: A trigger on a source in state PQ=01 leaves the state at 01 and produces no notification.
- R5: An end-of-interrupt access (offset 3'b000) returns the old PQ and clears P; when Q was 0 the state becomes 00 and no notification is produced.
- R6: An end-of-interrupt access on a source with Q=1 leaves the state at PQ=10 and produces one fresh notification for that source.
- R7: Offsets 3'b001, 3'b010 and 3'b011 return the current PQ and change nothing.
- R8: Offset 3'b1xy writes PQ=xy, returns the old PQ and produces no notification.
- R9: Pending notifications are granted round-robin: the search starts at the source after the one granted last (source 0 after reset) and wraps around.
- R10: While `notif_valid_o` is high and `notif_ready_i` is low, `notif_valid_o` and `notif_src_o` stay stable, and notifications that arrive meanwhile are not lost.
- R11: The address is {source number, 3-bit offset}. Read data is presented in the cycle after the request, with `mmio_rvalid_o` high for that cycle.
- R12: When a software access and a trigger hit the same source in the same cycle, the access is applied first and the trigger acts on its result. The read data still returns the state from before both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NUM_SRC | One trigger pulse bit per source |
| mmio_valid_i | input | 1 | Software access request |
| mmio_addr_i | input | SRC_W+3 | {source number, operation offset} |
| mmio_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| mmio_rdata_o | output | 2 | PQ state before the access ({P,Q}) |
| notif_valid_o | output | 1 | Notification available |
| notif_src_o | output | SRC_W | Source number of the notification |
| notif_ready_i | input | 1 | Downstream accepts the notification |

## Verification
The state machine is driven from each of its four states by a trigger, so that forwarding is told apart from coalescing and from the off state. End-of-interrupt is applied with Q set and with Q clear, which separates replay from plain completion. Triggers on several sources in one cycle, after a known previous grant, show round-robin order rather than fixed priority. A held-off downstream ready and a trigger coinciding with an end-of-interrupt on the same source exercise stall handling and the ordering of the two actions.

// File: rtl/pq_pkg.sv
package pq_pkg;

   typedef logic [1:0] pq_t;

   localparam pq_t PQ_IDLE   = 2'b00;
   localparam pq_t PQ_OFF    = 2'b01;
   localparam pq_t PQ_PEND   = 2'b10;
   localparam pq_t PQ_PEND_Q = 2'b11;

   localparam int OP_W = 3;

   typedef enum logic [1:0] {
      ACC_EOI  = 2'd0,
      ACC_READ = 2'd1,
      ACC_SET  = 2'd2
   } acc_kind_e;

   typedef struct packed {
      pq_t  pq;
      logic fwd;
   } pq_step_t;

   function automatic acc_kind_e decode_offset(input logic [OP_W-1:0] off);
      if (off[2])
         return ACC_SET;
      else if (off[1:0] == 2'b00)
         return ACC_EOI;
      else
         return ACC_READ;
   endfunction

   function automatic pq_step_t step_trigger(input pq_t cur);
      pq_step_t r;
      r.fwd = 1'b0;
      r.pq  = cur;
      unique case (cur)
         PQ_IDLE: begin
            r.pq  = PQ_PEND;
            r.fwd = 1'b1;
         end
         PQ_OFF:  r.pq = PQ_OFF;
         default: r.pq = PQ_PEND_Q;
      endcase
      return r;
   endfunction

   function automatic pq_step_t step_access(input acc_kind_e kind,
                                            input pq_t set_val,
                                            input pq_t cur);
      pq_step_t r;
      r.fwd = 1'b0;
      r.pq  = cur;
      unique case (kind)
         ACC_EOI: begin
            if (cur[0] && cur[1]) begin
               r.pq  = PQ_PEND;
               r.fwd = 1'b1;
            end else if (cur[1]) begin
               r.pq = PQ_IDLE;
            end else begin
               r.pq = cur;
            end
         end
         ACC_SET: r.pq = set_val;
         default: r.pq = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pq_cell.sv
module pq_cell
   import pq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig_i,
   input  logic      acc_hit_i,
   input  acc_kind_e acc_kind_i,
   input  pq_t       acc_set_i,
   input  logic      gnt_i,
   output pq_t       pq_o,
   output logic      fwd_o
);

   pq_t      pq_q;
   logic     fwd_q;
   pq_step_t after_acc;
   pq_step_t after_trig;

   always_comb begin
      if (acc_hit_i)
         after_acc = step_access(acc_kind_i, acc_set_i, pq_q);
      else
         after_acc = '{pq: pq_q, fwd: 1'b0};

      if (trig_i)
         after_trig = step_trigger(after_acc.pq);
      else
         after_trig = '{pq: after_acc.pq, fwd: 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pq_q  <= PQ_OFF;
         fwd_q <= 1'b0;
      end else begin
         pq_q  <= after_trig.pq;
         fwd_q <= (fwd_q & ~gnt_i) | after_acc.fwd | after_trig.fwd;
      end
   end

   assign pq_o  = pq_q;
   assign fwd_o = fwd_q;

   AST_COALESCE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !acc_hit_i && pq_q[1]) |=> (pq_q == PQ_PEND_Q)); // R3

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !acc_hit_i && pq_q == PQ_OFF && !fwd_q) |=> (pq_q == PQ_OFF && !fwd_q)); // R4

   AST_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit_i && acc_kind_i == ACC_EOI && pq_q == PQ_PEND_Q && !trig_i)
      |=> (pq_q == PQ_PEND && fwd_q)); // R6

   AST_GNT_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_i |-> fwd_q); // R9

endmodule

// File: rtl/pq_rr_arb.sv
module pq_rr_arb #(
   parameter int NUM_REQ = 16,
   localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_i,
   input  logic               take_i,
   output logic [NUM_REQ-1:0] gnt_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic               any_o
);

   localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(NUM_REQ - 1);

   logic [IDX_W-1:0]   last_q;
   logic [NUM_REQ-1:0] pick;

   generate
      if (NUM_REQ < 2) begin : g_bad
         $error("pq_rr_arb needs at least two requesters");
      end
   endgenerate

   always_comb begin
      pick  = '0;
      idx_o = '0;
      any_o = 1'b0;
      for (int k = 0; k < NUM_REQ; k++) begin
         int c;
         c = (int'(last_q) + 1 + k) % NUM_REQ;
         if (!any_o && req_i[c]) begin
            any_o   = 1'b1;
            pick[c] = 1'b1;
            idx_o   = IDX_W'(c);
         end
      end
   end

   assign gnt_o = take_i ? pick : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_q <= LAST_RST;
      else if (take_i && any_o)
         last_q <= idx_o;
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R9

   AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_o & ~req_i) == '0)); // R9

endmodule

// File: rtl/pq_notify_out.sv
module pq_notify_out #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             take_o,
   output logic             valid_o,
   output logic [IDX_W-1:0] src_o,
   input  logic             ready_i
);

   logic             valid_q;
   logic [IDX_W-1:0] src_q;

   assign take_o = any_i && (!valid_q || ready_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         src_q   <= '0;
      end else if (take_o) begin
         valid_q <= 1'b1;
         src_q   <= idx_i;
      end else if (ready_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign src_o   = src_q;

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready_i) |=> (valid_q && $stable(src_q))); // R10

endmodule

// File: rtl/pq_src_array.sv
module pq_src_array
   import pq_pkg::*;
#(
   parameter int NUM_SRC = 16,
   localparam int SRC_W  = $clog2(NUM_SRC),
   localparam int ADDR_W = SRC_W + OP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] trig_i,
   input  logic               mmio_valid_i,
   input  logic [ADDR_W-1:0]  mmio_addr_i,
   output logic               mmio_rvalid_o,
   output logic [1:0]         mmio_rdata_o,
   output logic               notif_valid_o,
   output logic [SRC_W-1:0]   notif_src_o,
   input  logic               notif_ready_i
);

   generate
      if (NUM_SRC < 2) begin : g_bad_n
         $error("pq_src_array needs NUM_SRC >= 2");
      end
   endgenerate

   logic [SRC_W-1:0]   acc_src;
   logic [OP_W-1:0]    acc_off;
   acc_kind_e          acc_kind;
   pq_t                acc_set;
   logic               acc_in_range;

   pq_t                pq_vec  [NUM_SRC];
   logic [NUM_SRC-1:0] fwd_vec;
   logic [NUM_SRC-1:0] gnt_vec;
   logic [SRC_W-1:0]   arb_idx;
   logic               arb_any;
   logic               take;

   logic               rvalid_q;
   pq_t                rdata_q;
   pq_t                old_pq;

   assign acc_src      = mmio_addr_i[ADDR_W-1:OP_W];
   assign acc_off      = mmio_addr_i[OP_W-1:0];
   assign acc_kind     = decode_offset(acc_off);
   assign acc_set      = acc_off[1:0];
   assign acc_in_range = (int'(acc_src) < NUM_SRC);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic hit;
      assign hit = mmio_valid_i && (acc_src == SRC_W'(i));
      pq_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .trig_i     (trig_i[i]),
         .acc_hit_i  (hit),
         .acc_kind_i (acc_kind),
         .acc_set_i  (acc_set),
         .gnt_i      (gnt_vec[i]),
         .pq_o       (pq_vec[i]),
         .fwd_o      (fwd_vec[i])
      );
   end

   always_comb begin
      old_pq = PQ_IDLE;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (acc_src == SRC_W'(i))
            old_pq = pq_vec[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= PQ_IDLE;
      end else begin
         rvalid_q <= mmio_valid_i;
         if (mmio_valid_i)
            rdata_q <= acc_in_range ? old_pq : PQ_IDLE;
      end
   end

   assign mmio_rvalid_o = rvalid_q;
   assign mmio_rdata_o  = rdata_q;

   pq_rr_arb #(.NUM_REQ(NUM_SRC)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (fwd_vec),
      .take_i (take),
      .gnt_o  (gnt_vec),
      .idx_o  (arb_idx),
      .any_o  (arb_any)
   );

   pq_notify_out #(.IDX_W(SRC_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_i   (arb_any),
      .idx_i   (arb_idx),
      .take_o  (take),
      .valid_o (notif_valid_o),
      .src_o   (notif_src_o),
      .ready_i (notif_ready_i)
   );

   AST_RDATA_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      mmio_valid_i |=> mmio_rvalid_o); // R11

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mmio_valid_i |=> !mmio_rvalid_o); // R11

endmodule

// File: tb/pq_src_array_tb.sv
module pq_src_array_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 16;
   localparam int SW         = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  trig = '0;
   logic          mmio_valid = 1'b0;
   logic [SW+2:0] mmio_addr = '0;
   logic          mmio_rvalid;
   logic [1:0]    mmio_rdata;
   logic          notif_valid;
   logic [SW-1:0] notif_src;
   logic          notif_ready = 1'b0;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pq_src_array #(.NUM_SRC(N)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .trig_i        (trig),
      .mmio_valid_i  (mmio_valid),
      .mmio_addr_i   (mmio_addr),
      .mmio_rvalid_o (mmio_rvalid),
      .mmio_rdata_o  (mmio_rdata),
      .notif_valid_o (notif_valid),
      .notif_src_o   (notif_src),
      .notif_ready_i (notif_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic access(input int src, input logic [2:0] off, output logic [1:0] rd);
      mmio_valid = 1'b1;
      mmio_addr  = {src[SW-1:0], off};
      @(negedge clk);
      mmio_valid = 1'b0;
      rd = mmio_rdata;
      chk(mmio_rvalid == 1'b1, "R11 rvalid", int'(mmio_rvalid), 1);
   endtask

   task automatic read_expect(input int src, input logic [1:0] exp, input string req);
      logic [1:0] rd;
      access(src, 3'b001, rd);
      chk(rd == exp, req, int'(rd), int'(exp));
   endtask

   task automatic pulse(input logic [N-1:0] bits);
      trig = bits;
      @(negedge clk);
      trig = '0;
   endtask

   task automatic expect_notif(input int src, input string req);
      int n = 0;
      while (!notif_valid && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(notif_valid == 1'b1, req, int'(notif_valid), 1);
      chk(int'(notif_src) == src, req, int'(notif_src), src);
      notif_ready = 1'b1;
      @(negedge clk);
      notif_ready = 1'b0;
   endtask

   task automatic expect_quiet(input string req);
      bit seen = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (notif_valid) seen = 1;
      end
      chk(!seen, req, int'(seen), 0);
   endtask

   task automatic t_reset;
      chk(notif_valid == 1'b0, "R1 valid after reset", int'(notif_valid), 0);
      for (int s = 0; s < N; s++)
         read_expect(s, 2'b01, "R1 reset state");
   endtask

   task automatic t_single;
      logic [1:0] rd;
      access(3, 3'b100, rd);                   // R8 set to 00
      chk(rd == 2'b01, "R8 old value", int'(rd), 1);
      expect_quiet("R8 no notif on set");
      read_expect(3, 2'b00, "R8 written");
      pulse(N'(1) << 3);
      expect_notif(3, "R2 forward");
      read_expect(3, 2'b10, "R2 state");
      access(3, 3'b010, rd);                   // R7 alias read
      chk(rd == 2'b10, "R7 read alias", int'(rd), 2);
      access(3, 3'b011, rd);
      chk(rd == 2'b10, "R7 read alias2", int'(rd), 2);
      pulse(N'(1) << 3);
      expect_quiet("R3 coalesce no notif");
      read_expect(3, 2'b11, "R3 state");
      pulse(N'(1) << 3);
      expect_quiet("R3 coalesce again");
      read_expect(3, 2'b11, "R3 stays 11");
      access(3, 3'b000, rd);                   // EOI with Q
      chk(rd == 2'b11, "R6 eoi old", int'(rd), 3);
      expect_notif(3, "R6 replay");
      read_expect(3, 2'b10, "R6 state");
      access(3, 3'b000, rd);
      chk(rd == 2'b10, "R5 eoi old", int'(rd), 2);
      expect_quiet("R5 no notif");
      read_expect(3, 2'b00, "R5 state");
   endtask

   task automatic t_off;
      logic [1:0] rd;
      pulse(N'(1) << 7);
      expect_quiet("R4 off no notif");
      read_expect(7, 2'b01, "R4 state");
      access(7, 3'b111, rd);
      chk(rd == 2'b01, "R8 set 11 old", int'(rd), 1);
      expect_quiet("R8 set 11 quiet");
      read_expect(7, 2'b11, "R8 set 11");
   endtask

   task automatic t_rr;
      logic [1:0] rd;
      access(2, 3'b100, rd);
      access(5, 3'b100, rd);
      access(9, 3'b100, rd);
      pulse(N'(1) << 5);
      expect_notif(5, "R9 first");
      pulse((N'(1) << 2) | (N'(1) << 9));
      expect_notif(9, "R9 after 5 comes 9");
      expect_notif(2, "R9 wrap to 2");
      access(0, 3'b100, rd);
      access(4, 3'b100, rd);
      access(8, 3'b100, rd);
      pulse((N'(1) << 0) | (N'(1) << 4) | (N'(1) << 8));
      expect_notif(4, "R9 after 2 comes 4");
      expect_notif(8, "R9 then 8");
      expect_notif(0, "R9 then 0");
   endtask

   task automatic t_hold;
      logic [1:0] rd;
      int n = 0;
      access(11, 3'b100, rd);
      access(12, 3'b100, rd);
      pulse(N'(1) << 11);
      while (!notif_valid && n < 20) begin
         @(negedge clk);
         n++;
      end
      pulse(N'(1) << 12);
      for (int k = 0; k < 5; k++) begin
         chk(notif_valid && notif_src == 4'd11, "R10 held", int'(notif_src), 11);
         @(negedge clk);
      end
      expect_notif(11, "R10 held entry");
      expect_notif(12, "R10 not lost");
   endtask

   task automatic t_same;
      logic [1:0] rd;
      access(6, 3'b100, rd);
      pulse(N'(1) << 6);
      expect_notif(6, "R12 prep");
      mmio_valid = 1'b1;
      mmio_addr  = {4'd6, 3'b000};
      trig       = N'(1) << 6;
      @(negedge clk);
      mmio_valid = 1'b0;
      trig       = '0;
      chk(mmio_rdata == 2'b10, "R12 old value", int'(mmio_rdata), 2);
      expect_notif(6, "R12 trigger after eoi");
      read_expect(6, 2'b10, "R12 state");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_single;
      t_off;
      t_rr;
      t_hold;
      t_same;
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule